// File: doc/BRIEF.md
# Handshaked Serial Byte Transfer Engine

This block is the device end of a byte-wide link to a host processor. Bytes pass through a shift-register data port, and three active-low handshake lines pace them. The host drives the transfer-in-progress line and the acknowledge line. The device drives the request line back to the host. A direction input selects which way the bytes flow. In host-to-device mode, each handshake event captures the shift-register byte into an outbound buffer. In device-to-host mode, each event presents the next byte of an inbound packet that local logic loaded earlier.

Handshake events are level changes, not clock edges. While a transfer is in progress, any change of the sampled acknowledge/in-progress pair moves exactly one byte. When the host releases in-progress, the block closes the transfer. If bytes were captured, it reports a completed packet together with its length. Every byte movement and every closing raises a shift-register interrupt. That interrupt can be held back by a programmable number of clock cycles, which gives the host time to settle. A typical value is 300 µs, which is 37500 cycles at 125 MHz. The request line tells the host two things: that the inbound packet has ended, and that unread data is waiting.

Both handshake lines pass through one sampling register before any decision uses them. Every decision therefore compares the newest sample against the one taken a cycle earlier.

Top module: `hs_xfer_engine`

## Requirements
- R1: After reset, `dev_req_n` is 1, `sr_irq` is 0 and `pkt_valid` is 0.
- R2: A byte moves only while the sampled `host_tip_n` is 0, and only in a cycle where the sampled pair {`host_ack_n`, `host_tip_n`} differs from the previous sample. This includes the cycle in which `host_tip_n` first falls. With no change, no byte moves and no interrupt is raised.
- R3: With `dir_h2d`=1, each move stores `sr_in` at the next outbound slot while fewer than DEPTH bytes are held. Once DEPTH bytes are held, further moves are dropped and raise no interrupt. Slot i is read on `out_rd_data` one cycle after `out_rd_addr`=i.
- R4: With `dir_h2d`=0, each move loads the next unread inbound byte onto `sr_out`. The move that consumes the last byte drives `dev_req_n` to 1.
- R5: When the sampled `host_tip_n` rises from 0 to 1, an interrupt is always raised. If the outbound count is nonzero, `pkt_valid` pulses for one cycle, `pkt_len` holds the count, and the count returns to 0.
- R6: With `host_tip_n` at 1 in both the current and the previous sample, a change of `host_ack_n` sets `dev_req_n` equal to the sampled `host_ack_n` and raises an interrupt.
- R7: With `host_tip_n` at 1 and no acknowledge change to act on, `dev_req_n` is driven to 0 whenever unread inbound bytes remain.
- R8: When `irq_delay` is 0 or `irq_bypass` is 1, `sr_irq` pulses for one cycle in the cycle after the request.
- R9: Otherwise `sr_irq` pulses `irq_delay` cycles later than it would without a delay. A new request that arrives while a delay is running restarts the count.
- R10: A pulse on `in_commit` makes the bytes pushed through `in_wr_en` since the last commit the new inbound packet. It resets the read position to its first byte and raises an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_tip_n | input | 1 | Transfer in progress from host, active low |
| host_ack_n | input | 1 | Acknowledge from host, active low |
| dev_req_n | output | 1 | Request to host, active low, registered |
| dir_h2d | input | 1 | 1: host-to-device capture, 0: device-to-host delivery |
| sr_in | input | 8 | Shift-register byte written by the host |
| sr_out | output | 8 | Shift-register byte presented to the host |
| irq_bypass | input | 1 | Port lines all outputs: interrupt fires without delay |
| irq_delay | input | DW | Interrupt delay in clock cycles |
| sr_irq | output | 1 | Shift-register interrupt pulse |
| in_wr_en | input | 1 | Push `in_wr_data` into the inbound packet being built |
| in_wr_data | input | 8 | Inbound byte |
| in_commit | input | 1 | Publish the pushed bytes as the inbound packet |
| pkt_valid | output | 1 | One-cycle pulse: host packet completed |
| pkt_len | output | CW | Length of the completed host packet |
| out_rd_addr | input | AW | Outbound buffer read address |
| out_rd_data | output | 8 | Outbound byte, one cycle after address |

## Verification
The hardest situations to reach are the ones where a request arrives while an earlier delay is still counting, and where the host keeps toggling acknowledge after the buffer is full. Both depend on the exact placement of handshake edges relative to the sampling register. The stimulus reaches them with a small buffer depth, so overflow takes only a few toggles. It also issues a second acknowledge toggle a fixed three cycles after the first, inside a short programmed delay. It then checks cycle by cycle that the interrupt appears only at the restarted time.

// File: rtl/hs_xfer_pkg.sv
package hs_xfer_pkg;
  typedef struct packed {
    logic ack;
    logic tip;
  } hs_lines_t;

  localparam hs_lines_t LINES_IDLE = '{ack: 1'b1, tip: 1'b1};
endpackage

// File: rtl/hs_line_sampler.sv
module hs_line_sampler
  import hs_xfer_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ack_n,
  input  logic      tip_n,
  output hs_lines_t cur,
  output hs_lines_t prev
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= LINES_IDLE;
      prev <= LINES_IDLE;
    end else begin
      cur  <= '{ack: ack_n, tip: tip_n};
      prev <= cur;
    end
  end
endmodule

// File: rtl/hs_byte_ram.sv
module hs_byte_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/hs_irq_delay.sv
module hs_irq_delay #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          bypass,
  input  logic [DW-1:0] delay,
  output logic          irq
);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (req) begin
        if (bypass || delay == '0) begin
          irq <= 1'b1;
          cnt <= '0;
        end else begin
          cnt <= delay;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == DW'(1)) irq <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hs_xfer_engine.sv
module hs_xfer_engine
  import hs_xfer_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_tip_n,
  input  logic          host_ack_n,
  output logic          dev_req_n,
  input  logic          dir_h2d,
  input  logic [7:0]    sr_in,
  output logic [7:0]    sr_out,
  input  logic          irq_bypass,
  input  logic [DW-1:0] irq_delay,
  output logic          sr_irq,
  input  logic          in_wr_en,
  input  logic [7:0]    in_wr_data,
  input  logic          in_commit,
  output logic          pkt_valid,
  output logic [CW-1:0] pkt_len,
  input  logic [AW-1:0] out_rd_addr,
  output logic [7:0]    out_rd_data
);
  hs_lines_t cur, prev;

  logic [CW-1:0] out_cnt;
  logic [CW-1:0] in_wptr;
  logic [CW-1:0] in_size;
  logic [CW-1:0] rd_idx;

  logic tip_on, pair_chg, in_left;
  logic cap, move_in, idle_ack, xfer_end, irq_req;

  hs_line_sampler u_smp (
    .clk  (clk),
    .rst  (rst),
    .ack_n(host_ack_n),
    .tip_n(host_tip_n),
    .cur  (cur),
    .prev (prev)
  );

  // event decode on sampled handshake
  always_comb begin
    tip_on   = ~cur.tip;
    pair_chg = (cur != prev);
    in_left  = (rd_idx < in_size);
    cap      = tip_on & dir_h2d & pair_chg & (out_cnt < CW'(DEPTH));
    move_in  = tip_on & ~dir_h2d & pair_chg & in_left & ~in_commit;
    idle_ack = ~tip_on & prev.tip & (cur.ack != prev.ack);
    xfer_end = ~tip_on & ~prev.tip;
    irq_req  = cap | move_in | idle_ack | xfer_end | in_commit;
  end

  // outbound capture and packet close
  always_ff @(posedge clk) begin
    if (rst) begin
      out_cnt   <= '0;
      pkt_valid <= 1'b0;
      pkt_len   <= '0;
    end else begin
      pkt_valid <= 1'b0;
      if (cap) begin
        out_cnt <= out_cnt + 1'b1;
      end else if (xfer_end && out_cnt != '0) begin
        pkt_valid <= 1'b1;
        pkt_len   <= out_cnt;
        out_cnt   <= '0;
      end
    end
  end

  // inbound packet build and read position
  always_ff @(posedge clk) begin
    if (rst) begin
      in_wptr <= '0;
      in_size <= '0;
      rd_idx  <= '0;
    end else begin
      if (in_commit) begin
        in_size <= in_wptr;
        in_wptr <= '0;
        rd_idx  <= '0;
      end else begin
        if (in_wr_en && in_wptr < CW'(DEPTH)) in_wptr <= in_wptr + 1'b1;
        if (move_in) rd_idx <= rd_idx + 1'b1;
      end
    end
  end

  // request line
  always_ff @(posedge clk) begin
    if (rst) begin
      dev_req_n <= 1'b1;
    end else if (move_in) begin
      if (rd_idx + 1'b1 >= in_size) dev_req_n <= 1'b1;
    end else if (idle_ack) begin
      dev_req_n <= cur.ack;
    end else if (~tip_on && in_left) begin
      dev_req_n <= 1'b0;
    end
  end

  hs_byte_ram #(.DEPTH(DEPTH), .W(8)) u_out_ram (
    .clk  (clk),
    .we   (cap),
    .waddr(out_cnt[AW-1:0]),
    .wdata(sr_in),
    .re   (1'b1),
    .raddr(out_rd_addr),
    .rdata(out_rd_data)
  );

  hs_byte_ram #(.DEPTH(DEPTH), .W(8)) u_in_ram (
    .clk  (clk),
    .we   (in_wr_en && !in_commit && in_wptr < CW'(DEPTH)),
    .waddr(in_wptr[AW-1:0]),
    .wdata(in_wr_data),
    .re   (move_in),
    .raddr(rd_idx[AW-1:0]),
    .rdata(sr_out)
  );

  hs_irq_delay #(.DW(DW)) u_dly (
    .clk   (clk),
    .rst   (rst),
    .req   (irq_req),
    .bypass(irq_bypass),
    .delay (irq_delay),
    .irq   (sr_irq)
  );
endmodule

// File: rtl/hs_xfer_checker.sv
module hs_xfer_checker #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] out_cnt,
  input logic [CW-1:0] rd_idx,
  input logic [CW-1:0] in_size,
  input logic          move_in,
  input logic          idle_ack,
  input logic          irq_req,
  input logic          cur_ack,
  input logic          dev_req_n,
  input logic          irq_bypass,
  input logic [DW-1:0] irq_delay,
  input logic          sr_irq,
  input logic          pkt_valid,
  input logic [CW-1:0] pkt_len
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    out_cnt <= CW'(DEPTH));

  p_last_byte_r4: assert property (@(posedge clk) disable iff (rst)
    (move_in && (rd_idx + 1'b1) == in_size) |=> dev_req_n);

  p_pkt_close_r5: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> (out_cnt == '0 && pkt_len != '0));

  p_ack_follow_r6: assert property (@(posedge clk) disable iff (rst)
    idle_ack |=> (dev_req_n == $past(cur_ack)));

  p_fast_irq_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_req && (irq_bypass || irq_delay == '0)) |=> sr_irq);

  p_rd_bound_r10: assert property (@(posedge clk) disable iff (rst)
    rd_idx <= in_size);
endmodule

bind hs_xfer_engine hs_xfer_checker #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_cnt   (out_cnt),
  .rd_idx    (rd_idx),
  .in_size   (in_size),
  .move_in   (move_in),
  .idle_ack  (idle_ack),
  .irq_req   (irq_req),
  .cur_ack   (cur.ack),
  .dev_req_n (dev_req_n),
  .irq_bypass(irq_bypass),
  .irq_delay (irq_delay),
  .sr_irq    (sr_irq),
  .pkt_valid (pkt_valid),
  .pkt_len   (pkt_len)
);

// File: tb/sim_hs_xfer_engine.sv
`timescale 1ns/1ps
module sim_hs_xfer_engine;
  localparam int DEPTH = 4;
  localparam int DW    = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_tip_n = 1'b1, host_ack_n = 1'b1, dir_h2d = 1'b1;
  logic [7:0] sr_in = '0, in_wr_data = '0;
  logic irq_bypass = 1'b0, in_wr_en = 1'b0, in_commit = 1'b0;
  logic [DW-1:0] irq_delay = '0;
  logic [AW-1:0] out_rd_addr = '0;
  logic dev_req_n, sr_irq, pkt_valid;
  logic [7:0] sr_out, out_rd_data;
  logic [CW-1:0] pkt_len;

  int tests = 0, fails = 0;
  int exp_len[$];
  logic ack_v = 1'b1;

  always #4 clk = ~clk;

  hs_xfer_engine #(.DEPTH(DEPTH), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .host_tip_n(host_tip_n), .host_ack_n(host_ack_n),
    .dev_req_n(dev_req_n), .dir_h2d(dir_h2d), .sr_in(sr_in), .sr_out(sr_out),
    .irq_bypass(irq_bypass), .irq_delay(irq_delay), .sr_irq(sr_irq),
    .in_wr_en(in_wr_en), .in_wr_data(in_wr_data), .in_commit(in_commit),
    .pkt_valid(pkt_valid), .pkt_len(pkt_len), .out_rd_addr(out_rd_addr),
    .out_rd_data(out_rd_data)
  );

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: completed packet lengths
  always @(negedge clk) begin
    if (!rst && pkt_valid) begin
      if (exp_len.size() == 0) check("R5 unexpected packet", 1, 0);
      else check("R5 packet length", int'(pkt_len), exp_len.pop_front());
    end
  end

  // drive lines at a falling edge; outputs settle two edges later
  task automatic lines(logic a, logic t);
    host_ack_n = a; host_tip_n = t; ack_v = a;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic push_in(logic [7:0] b);
    in_wr_en = 1'b1; in_wr_data = b; @(negedge clk); in_wr_en = 1'b0;
  endtask

  task automatic commit_in();
    in_commit = 1'b1; @(negedge clk); in_commit = 1'b0;
    check("R10 commit irq", sr_irq, 1);
    @(negedge clk);
    check("R7 pending request", dev_req_n, 0);
  endtask

  task automatic read_out(int i, logic [7:0] exp);
    out_rd_addr = AW'(i); @(negedge clk); @(negedge clk);
    check("R3 stored byte", out_rd_data, exp);
  endtask

  initial begin
    #1_000_000;
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 req idle", dev_req_n, 1);
    check("R1 irq idle", sr_irq, 0);
    check("R1 pkt idle", pkt_valid, 0);

    // host-to-device, three bytes
    dir_h2d = 1'b1;
    sr_in = 8'hA1; lines(1'b1, 1'b0);
    check("R2 byte on tip fall irq", sr_irq, 1);
    @(negedge clk); check("R2 no change no irq", sr_irq, 0);
    @(negedge clk); check("R2 no change no irq", sr_irq, 0);
    sr_in = 8'hA2; lines(1'b0, 1'b0); check("R2 ack toggle irq", sr_irq, 1);
    sr_in = 8'hA3; lines(1'b1, 1'b0); check("R2 ack toggle irq", sr_irq, 1);
    exp_len.push_back(3);
    lines(1'b1, 1'b1);
    check("R5 end irq", sr_irq, 1);
    check("R5 packet pulse", pkt_valid, 1);
    read_out(0, 8'hA1); read_out(1, 8'hA2); read_out(2, 8'hA3);

    // overflow: six moves into four slots
    sr_in = 8'hB0; lines(1'b1, 1'b0);
    for (int i = 1; i < 6; i++) begin
      sr_in = 8'hB0 + 8'(i);
      lines(~ack_v, 1'b0);
      check("R3 irq only while room", sr_irq, (i < DEPTH) ? 1 : 0);
    end
    exp_len.push_back(DEPTH);
    lines(ack_v, 1'b1);
    check("R3 full packet closes", pkt_valid, 1);
    read_out(3, 8'hB3);
    read_out(0, 8'hB0);

    // device-to-host, three bytes
    dir_h2d = 1'b0;
    push_in(8'hC0); push_in(8'hC1); push_in(8'hC2);
    commit_in();
    lines(ack_v, 1'b0);
    check("R4 first byte", sr_out, 8'hC0);
    check("R4 req still low", dev_req_n, 0);
    lines(~ack_v, 1'b0); check("R4 second byte", sr_out, 8'hC1);
    lines(~ack_v, 1'b0);
    check("R4 last byte", sr_out, 8'hC2);
    check("R4 end of packet req", dev_req_n, 1);
    lines(~ack_v, 1'b0);
    check("R2 nothing left no irq", sr_irq, 0);
    check("R2 byte held", sr_out, 8'hC2);
    lines(ack_v, 1'b1);
    check("R5 end irq no packet", sr_irq, 1);
    check("R5 no packet when empty", pkt_valid, 0);
    @(negedge clk);

    // idle acknowledge follow
    lines(1'b0, 1'b1);
    check("R6 req follows ack low", dev_req_n, 0);
    check("R6 irq", sr_irq, 1);
    @(negedge clk);
    check("R6 req holds", dev_req_n, 0);
    lines(1'b1, 1'b1);
    check("R6 req follows ack high", dev_req_n, 1);

    // new packet restarts read position
    push_in(8'hD0); push_in(8'hD1);
    commit_in();
    lines(ack_v, 1'b0); check("R10 read from start", sr_out, 8'hD0);
    lines(ack_v, 1'b1);
    @(negedge clk);
    check("R7 unread remains", dev_req_n, 0);
    lines(ack_v, 1'b0);
    lines(~ack_v, 1'b0); check("R4 second byte", sr_out, 8'hD1);
    lines(ack_v, 1'b1);
    repeat (2) @(negedge clk);

    // delayed interrupt
    irq_delay = 8'd5;
    host_ack_n = ~ack_v; ack_v = ~ack_v;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      check("R9 delayed irq timing", sr_irq, (k == 7) ? 1 : 0);
    end
    // restart
    host_ack_n = ~ack_v; ack_v = ~ack_v;
    repeat (3) @(negedge clk);
    host_ack_n = ~ack_v; ack_v = ~ack_v;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      check("R9 restarted irq timing", sr_irq, (k == 7) ? 1 : 0);
    end
    // bypass
    irq_bypass = 1'b1;
    lines(~ack_v, 1'b1);
    check("R8 bypass immediate", sr_irq, 1);
    @(negedge clk);
    check("R8 single pulse", sr_irq, 0);

    repeat (3) @(negedge clk);
    check("R5 all packets seen", exp_len.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule